// File: doc/BRIEF.md
# 64-bit Register-Pair Shift Unit

This unit takes two 32-bit words, joins them into one 64-bit operand with the high word in the upper half, and applies one of eight operations to it. The operations are a plain left shift, two plain right shifts, two saturating left shifts and two rounding right shifts, plus a pass-through. The result is returned as a low word and a high word. A sticky saturation flag records that a saturating left shift overflowed. The flag stays set until a clear pulse removes it.

Operands arrive on a valid/ready input stream. Results leave on a valid/ready output stream after one register stage. A result waits in the output register while `out_ready` is low. In that state `in_ready` is low, so no new operand is taken until the held result is consumed. When a result is consumed and a new operand is accepted on the same edge, the stream runs at full rate.

Top module: `pshift_unit`

## Requirements
- R1: The operand is X = {in_hi, in_lo}. The result R appears as out_lo = R[31:0] and out_hi = R[63:32]. Operation codes on in_op are: 0 left shift, 1 logical right, 2 arithmetic right, 3 signed saturating left, 4 unsigned saturating left, 5 signed rounding right, 6 unsigned rounding right, 7 pass-through.
- R2: Codes 0 and 1 read in_amt as unsigned (0 to 255). Bits cross between the two words, and an amount of 64 or more gives zero.
- R3: Code 2 shifts X right and fills with X[63]. An amount of 64 or more gives a word of copies of X[63].
- R4: Code 3 with a count c from 0 to 127 (in_amt as signed 8-bit) returns X<<c when that value still reads as X under an arithmetic right shift by c. Otherwise the shift has overflowed: the result clamps to 0x7FFF_FFFF_FFFF_FFFF when X is non-negative and to 0x8000_0000_0000_0000 when X is negative.
- R5: Code 4 with c from 0 to 127 returns X<<c when no set bit is lost. Otherwise the shift has overflowed and the result clamps to all ones.
- R6: Codes 3 and 4 with a negative count (in_amt[7] = 1) shift right by the magnitude. Code 3 shifts arithmetically and code 4 logically. Such an operation never sets the flag.
- R7: Codes 5 and 6 read in_amt as unsigned n. The result is the truncated right shift (arithmetic for 5, logical for 6) plus the last bit shifted out, X[n-1]. When n > 64 that bit is X[63] for code 5 and 0 for code 6. When n = 0 the operand passes unchanged.
- R8: An accepted operation that overflows under R4 or R5 sets sat_flag on the edge that loads its result. The flag then stays set until sat_clr is high at an edge. A new overflow wins over a clear on the same edge.
- R9: Operations other than an overflowing saturating left shift leave sat_flag unchanged.
- R10: in_ready = !out_valid || out_ready. A transfer on the input loads the result one edge later. While out_valid is high and out_ready is low, out_lo and out_hi hold.
- R11: During reset (rst_n low), out_valid and sat_flag are 0.
- R12: Code 7 returns X unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can take an operand |
| in_lo | input | 32 | Low operand word |
| in_hi | input | 32 | High operand word |
| in_op | input | 3 | Operation code (R1) |
| in_amt | input | 8 | Shift amount or signed count |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_lo | output | 32 | Low result word |
| out_hi | output | 32 | High result word |
| sat_flag | output | 1 | Sticky saturation flag |
| sat_clr | input | 1 | Clears the sticky flag |

## Verification
The bench targets these corner cases:
- Shift amounts at and past 32 and 64, which expose a design that shifts each word on its own or wraps the amount modulo 64.
- Saturating shifts that sit exactly on the edge: all ones shifted by 63 must not overflow, while 0x4000... shifted by 1 must clamp. A design that tests only the top bit gets one of these wrong.
- Rounding of all ones by one, which needs the carry. Rounding past 64 with a negative operand must give zero rather than minus one.
- Negative counts, which must not raise the flag.
- Back-pressure while a second operand waits, and a clear that lands on the same edge as an overflow. A design that drops data, or lets the clear win, fails these.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  typedef enum logic [2:0] {
    OP_SHL       = 3'd0,
    OP_SHR_LOG   = 3'd1,
    OP_SHR_ARI   = 3'd2,
    OP_SAT_SHL_S = 3'd3,
    OP_SAT_SHL_U = 3'd4,
    OP_RND_SHR_S = 3'd5,
    OP_RND_SHR_U = 3'd6,
    OP_PASS      = 3'd7
  } pshift_op_e;
endpackage

// File: rtl/pshift_barrel.sv
module pshift_barrel #(
  parameter int W  = 64,
  parameter int AW = 8
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);
  localparam int SW = $clog2(W);

  logic         fill;
  logic [W-1:0] fillv;
  logic         big;
  logic [W-1:0] stg [0:SW];

  assign fill   = arith & ~left & din[W-1];
  assign fillv  = {W{fill}};
  assign stg[0] = din;

  // one log stage per amount bit below the word size
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] l_sh;
    logic [W-1:0] r_sh;
    assign l_sh       = stg[k] << S;
    assign r_sh       = (stg[k] >> S) | (fillv << (W - S));
    assign stg[k + 1] = amt[k] ? (left ? l_sh : r_sh) : stg[k];
  end

  // any amount bit at or above the word size empties the word
  assign big  = |amt[AW-1:SW];
  assign dout = big ? (left ? '0 : fillv) : stg[SW];
endmodule

// File: rtl/pshift_satl.sv
module pshift_satl #(
  parameter int W  = 64,
  parameter int AW = 8
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] cnt,
  input  logic          sgn,
  output logic [W-1:0]  dout,
  output logic          ovf
);
  logic          neg;
  logic [AW-1:0] mag;
  logic [W-1:0]  sh_l;
  logic [W-1:0]  back;
  logic [W-1:0]  sh_r;
  logic [W-1:0]  clamp;
  logic          lost;

  assign neg = cnt[AW-1];
  assign mag = neg ? (~cnt + 1'b1) : cnt;

  pshift_barrel #(.W(W), .AW(AW)) u_left (
    .din(din), .amt(mag), .left(1'b1), .arith(1'b0), .dout(sh_l));

  // undo the left shift; a mismatch means bits were lost
  pshift_barrel #(.W(W), .AW(AW)) u_back (
    .din(sh_l), .amt(mag), .left(1'b0), .arith(sgn), .dout(back));

  pshift_barrel #(.W(W), .AW(AW)) u_right (
    .din(din), .amt(mag), .left(1'b0), .arith(sgn), .dout(sh_r));

  assign lost = (back != din);

  always_comb begin
    if (sgn) clamp = din[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else     clamp = '1;
  end

  assign ovf  = ~neg & lost;
  assign dout = neg ? sh_r : (lost ? clamp : sh_l);
endmodule

// File: rtl/pshift_rndr.sv
module pshift_rndr #(
  parameter int W  = 64,
  parameter int AW = 8
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          sgn,
  output logic [W-1:0]  dout
);
  localparam int SW = $clog2(W);

  logic [W-1:0]  trunc;
  logic [AW-1:0] idx;
  logic          last;
  logic [W:0]    sum;

  pshift_barrel #(.W(W), .AW(AW)) u_tr (
    .din(din), .amt(amt), .left(1'b0), .arith(sgn), .dout(trunc));

  assign idx = amt - 1'b1;

  always_comb begin
    if (amt == '0)                last = 1'b0;
    else if (idx < AW'(W))        last = din[idx[SW-1:0]];
    else                          last = sgn & din[W-1];
  end

  // extra top bit keeps the carry of the increment
  assign sum  = {sgn & trunc[W-1], trunc} + {{W{1'b0}}, last};
  assign dout = sum[W-1:0];
endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
  import pshift_pkg::*;
#(
  parameter int HALF = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [HALF-1:0] in_lo,
  input  logic [HALF-1:0] in_hi,
  input  logic [2:0]      in_op,
  input  logic [AW-1:0]   in_amt,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [HALF-1:0] out_lo,
  output logic [HALF-1:0] out_hi,
  output logic            sat_flag,
  input  logic            sat_clr
);
  localparam int W = 2 * HALF;

  pshift_op_e   op;
  logic [W-1:0] x;
  logic [W-1:0] r_plain;
  logic [W-1:0] r_sat;
  logic [W-1:0] r_rnd;
  logic [W-1:0] r_sel;
  logic         sat_ovf;
  logic         is_sat;
  logic         accept;
  logic         sat_hit;
  logic [W-1:0] res_q;
  logic         vld_q;
  logic         flag_q;

  assign op = pshift_op_e'(in_op);
  assign x  = {in_hi, in_lo};

  pshift_barrel #(.W(W), .AW(AW)) u_plain (
    .din(x), .amt(in_amt), .left(op == OP_SHL), .arith(op == OP_SHR_ARI),
    .dout(r_plain));

  pshift_satl #(.W(W), .AW(AW)) u_sat (
    .din(x), .cnt(in_amt), .sgn(op == OP_SAT_SHL_S), .dout(r_sat),
    .ovf(sat_ovf));

  pshift_rndr #(.W(W), .AW(AW)) u_rnd (
    .din(x), .amt(in_amt), .sgn(op == OP_RND_SHR_S), .dout(r_rnd));

  always_comb begin
    unique case (op)
      OP_SHL, OP_SHR_LOG, OP_SHR_ARI: r_sel = r_plain;
      OP_SAT_SHL_S, OP_SAT_SHL_U:     r_sel = r_sat;
      OP_RND_SHR_S, OP_RND_SHR_U:     r_sel = r_rnd;
      default:                        r_sel = x;
    endcase
  end

  assign is_sat   = (op == OP_SAT_SHL_S) || (op == OP_SAT_SHL_U);
  assign in_ready = ~vld_q | out_ready;
  assign accept   = in_valid & in_ready;
  assign sat_hit  = accept & is_sat & sat_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      res_q <= r_sel;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (sat_hit) flag_q <= 1'b1;
    else if (sat_clr) flag_q <= 1'b0;
  end

  assign out_valid = vld_q;
  assign out_lo    = res_q[HALF-1:0];
  assign out_hi    = res_q[W-1:HALF];
  assign sat_flag  = flag_q;
endmodule

// File: rtl/pshift_unit_chk.sv
module pshift_unit_chk #(
  parameter int HALF = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [2:0]      in_op,
  input logic [AW-1:0]   in_amt,
  input logic            out_valid,
  input logic            out_ready,
  input logic [HALF-1:0] out_lo,
  input logic [HALF-1:0] out_hi,
  input logic            sat_flag,
  input logic            sat_clr
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lo) && $stable(out_hi));

  // R10
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(in_valid && in_ready && (in_op == 3'd3 || in_op == 3'd4)));

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sat_flag) |-> $past(sat_clr));

  // R9
  no_sat_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op != 3'd3 && in_op != 3'd4 && !sat_flag |=> !sat_flag);

  // R6
  neg_cnt_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == 3'd3 || in_op == 3'd4) && in_amt[AW-1] && !sat_flag
    |=> !sat_flag);

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !sat_flag);
endmodule

bind pshift_unit pshift_unit_chk #(.HALF(HALF), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_amt(in_amt), .out_valid(out_valid), .out_ready(out_ready),
  .out_lo(out_lo), .out_hi(out_hi), .sat_flag(sat_flag), .sat_clr(sat_clr));

// File: tb/tb_pshift_unit.sv
`timescale 1ns/1ps
module tb_pshift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_lo = '0;
  logic [31:0] in_hi = '0;
  logic [2:0]  in_op = '0;
  logic [7:0]  in_amt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_lo;
  logic [31:0] out_hi;
  logic        sat_flag;
  logic        sat_clr = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pshift_unit dut (.*);

  task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // drive one operation, check the result the cycle after acceptance
  task automatic run_op(string tag, logic [2:0] op, logic [63:0] x, logic [7:0] amt,
                        logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_hi = x[63:32]; in_lo = x[31:0]; in_amt = amt;
    @(negedge clk);
    in_valid = 1'b0;
    chk1({tag, " valid"}, out_valid, 1'b1);
    chk64(tag, {out_hi, out_lo}, exp);
  endtask

  task automatic clear_flag();
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk1("R11 out_valid in reset", out_valid, 1'b0);
    chk1("R11 sat_flag in reset", sat_flag, 1'b0);
  endtask

  task automatic t_plain();
    run_op("R1 shl cross word", 3'd0, 64'h00000001_80000001, 8'd1, 64'h00000003_00000002);
    run_op("R2 shl by 32", 3'd0, 64'h00000000_DEADBEEF, 8'd32, 64'hDEADBEEF_00000000);
    run_op("R2 shr by 4", 3'd1, 64'h12345678_9ABCDEF0, 8'd4, 64'h01234567_89ABCDEF);
    run_op("R2 shr by 64", 3'd1, 64'hFFFFFFFF_FFFFFFFF, 8'd64, 64'h0);
    run_op("R2 shl by 200", 3'd0, 64'h00000000_00000001, 8'd200, 64'h0);
    run_op("R3 asr by 32", 3'd2, 64'h80000000_00000000, 8'd32, 64'hFFFFFFFF_80000000);
    run_op("R3 asr by 100 neg", 3'd2, 64'h80000000_00000001, 8'd100, 64'hFFFFFFFF_FFFFFFFF);
    run_op("R3 asr by 100 pos", 3'd2, 64'h7FFFFFFF_FFFFFFFF, 8'd100, 64'h0);
    chk1("R9 plain ops keep flag clear", sat_flag, 1'b0);
  endtask

  task automatic t_sat_signed();
    run_op("R4 signed fits", 3'd3, 64'h1, 8'd62, 64'h40000000_00000000);
    run_op("R4 minus one by 63", 3'd3, 64'hFFFFFFFF_FFFFFFFF, 8'd63, 64'h80000000_00000000);
    chk1("R4 no overflow no flag", sat_flag, 1'b0);
    run_op("R4 neg edge fits", 3'd3, 64'hC0000000_00000000, 8'd1, 64'h80000000_00000000);
    chk1("R4 neg edge no flag", sat_flag, 1'b0);
    run_op("R4 pos overflow", 3'd3, 64'h40000000_00000000, 8'd1, 64'h7FFFFFFF_FFFFFFFF);
    chk1("R8 flag set on overflow", sat_flag, 1'b1);
    clear_flag();
    chk1("R8 flag cleared", sat_flag, 1'b0);
    run_op("R4 neg overflow", 3'd3, 64'hC0000000_00000000, 8'd2, 64'h80000000_00000000);
    chk1("R8 flag set neg overflow", sat_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_sat_unsigned();
    run_op("R5 unsigned fits", 3'd4, 64'h00000000_FFFFFFFF, 8'd32, 64'hFFFFFFFF_00000000);
    chk1("R5 no flag", sat_flag, 1'b0);
    run_op("R5 count 64 overflow", 3'd4, 64'h1, 8'd64, 64'hFFFFFFFF_FFFFFFFF);
    chk1("R5 flag set", sat_flag, 1'b1);
    clear_flag();
    run_op("R5 top bit lost", 3'd4, 64'h80000000_00000000, 8'd1, 64'hFFFFFFFF_FFFFFFFF);
    clear_flag();
  endtask

  task automatic t_neg_count();
    run_op("R6 signed neg count", 3'd3, 64'h80000000_00000000, 8'hFC, 64'hF8000000_00000000);
    run_op("R6 unsigned neg count", 3'd4, 64'h80000000_00000000, 8'hFC, 64'h08000000_00000000);
    run_op("R6 signed -128", 3'd3, 64'h80000000_00000000, 8'h80, 64'hFFFFFFFF_FFFFFFFF);
    run_op("R6 unsigned -128", 3'd4, 64'h80000000_00000000, 8'h80, 64'h0);
    chk1("R6 neg counts leave flag clear", sat_flag, 1'b0);
  endtask

  task automatic t_round();
    run_op("R7 unsigned round up", 3'd6, 64'h3, 8'd1, 64'h2);
    run_op("R7 carry all ones", 3'd6, 64'hFFFFFFFF_FFFFFFFF, 8'd1, 64'h80000000_00000000);
    run_op("R7 round by 32", 3'd6, 64'h00000001_80000000, 8'd32, 64'h2);
    run_op("R7 signed minus three", 3'd5, 64'hFFFFFFFF_FFFFFFFD, 8'd1, 64'hFFFFFFFF_FFFFFFFF);
    run_op("R7 signed minus one by 64", 3'd5, 64'hFFFFFFFF_FFFFFFFF, 8'd64, 64'h0);
    run_op("R7 signed beyond 64", 3'd5, 64'h80000000_00000000, 8'd90, 64'h0);
    run_op("R7 unsigned by 64", 3'd6, 64'h80000000_00000000, 8'd64, 64'h1);
    run_op("R7 amount zero", 3'd5, 64'h12345678_9ABCDEF1, 8'd0, 64'h12345678_9ABCDEF1);
  endtask

  task automatic t_pass();
    run_op("R12 pass-through", 3'd7, 64'hCAFEF00D_01234567, 8'd17, 64'hCAFEF00D_01234567);
  endtask

  task automatic t_sticky();
    run_op("R8 overflow for sticky", 3'd4, 64'hF0000000_00000000, 8'd4, 64'hFFFFFFFF_FFFFFFFF);
    run_op("R9 plain op after overflow", 3'd0, 64'h1, 8'd1, 64'h2);
    chk1("R9 flag kept by plain op", sat_flag, 1'b1);
    run_op("R9 non overflow sat op", 3'd4, 64'h1, 8'd1, 64'h2);
    chk1("R9 flag kept by fitting sat op", sat_flag, 1'b1);
    clear_flag();
    // overflow and clear on the same edge
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd3; in_hi = 32'h7FFFFFFF; in_lo = '0; in_amt = 8'd4;
    sat_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    chk1("R8 set beats clear", sat_flag, 1'b1);
    clear_flag();
    chk1("R8 clear after tie", sat_flag, 1'b0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd0; in_hi = '0; in_lo = 32'h1; in_amt = 8'd3;
    @(negedge clk);
    chk1("R10 first result valid", out_valid, 1'b1);
    chk1("R10 ready low when full", in_ready, 1'b0);
    in_op = 3'd1; in_hi = 32'h00000010; in_lo = '0; in_amt = 8'd4;
    repeat (3) @(negedge clk);
    chk64("R10 held result", {out_hi, out_lo}, 64'h8);
    chk1("R10 still blocked", in_ready, 1'b0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk1("R10 second result valid", out_valid, 1'b1);
    chk64("R10 second result", {out_hi, out_lo}, 64'h00000001_00000000);
    @(negedge clk);
    chk1("R10 drained", out_valid, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_sat_signed();
    t_sat_unsigned();
    t_neg_count();
    t_round();
    t_pass();
    t_sticky();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule